// File: doc/BRIEF.md
# Load/Store Data Watchpoint Comparator

This block sits beside a 32-bit processor's load/store path and raises a debug event when an access meets a programmed set of address and data conditions. It has two address comparators and two data comparators. Each one holds a reference value and a condition: off, equal, not equal, greater than or less than. Two comparators can be paired as a lower and an upper bound to form a range. Each data comparator also has a width mode (byte, half-word or word) and a 4-bit lane mask. With these, a narrow variable can be watched even when the program reads or writes it with a wider access.

Before any comparison, the data of a narrow access is replicated across the word so that every lane holds it. The address comparators drop the low address bits that a wider access cannot resolve. Software programs the block through a one-cycle register-write port.

A small state machine turns a matching access into a registered one-cycle event. Its states are ST_OFF (global enable low), ST_ARMED (enabled, no event) and ST_FIRE (event output high). It has three transitions. *disable* goes from any state to ST_OFF while the enable bit is clear. *hit* goes from ST_OFF, ST_ARMED or ST_FIRE to ST_FIRE on a valid access that matches while enabled. *miss* goes to ST_ARMED on any other cycle while enabled.

Top module: `ldst_watch`

## Requirements
- R1: Address comparison ignores address bits [1:0] of both the access address and the reference on a word access (size 2 or 3), ignores bit [0] on a half-word access (size 1), and uses all bits on a byte access (size 0).
- R2: A condition code selects the test: 1 equal, 2 not equal, 3 unsigned greater than the reference, 4 unsigned less than the reference. Codes 0, 5, 6 and 7 switch the comparator off.
- R3: Access data arrives right-justified in acc_data. Before comparison, a byte access is replicated into all four byte lanes and a half-word access into both half-word lanes. A word access is used as it is.
- R4: Data width mode 0 is byte, 1 is half-word, and 2 or 3 is word. In word mode the full 32-bit value is compared and the lane mask has no effect.
- R5: In byte mode, mask bit i excludes data bits [8i+7:8i]. Bit 0 is the byte at address offset 3. In half-word mode, a half (bits [31:16] or [15:0]) is excluded only when both of its mask bits are set. Every lane that is not excluded must meet the condition on its own. If all lanes are excluded, the comparator is true.
- R6: The event condition is the AND of all four comparators. A comparator that is off counts as true.
- R7: evt is high in the cycle after a valid access whose condition holds, and only then. It stays high for exactly one cycle per such access, and it never rises without acc_valid.
- R8: Global enable bit 0 of register 0 gates the event. While it is clear, evt stays low.
- R9: After reset, every comparator is off and the global enable is clear, so evt stays low until software programs the block.
- R10: cfg_sel selects the register that is written. 0 is control. 1 and 2 are the address references. 3 and 4 are the address conditions, in bits [2:0]. 5 and 6 are the data references. 7 and 8 are the data configurations: condition in [2:0], width in [5:4], mask in [11:8]. Other selects change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Load/store access strobe |
| acc_addr | input | 32 | Access byte address |
| acc_size | input | 2 | Access size: 0 byte, 1 half-word, 2/3 word |
| acc_data | input | 32 | Access data, right-justified |
| evt | output | 1 | One-cycle watchpoint event |

## Verification
The byte target at address 3, bounded by a range, is reached with byte, half-word and word accesses. This shows whether the address masking and the data replication work together, and whether the excluded lanes stay out of the result. The half-word range is tried with accesses where one half sits on a bound. This tells per-lane comparison apart from a whole-word comparison. Word-mode equality, lane-wise not-equal, the global enable and the all-off state are each tried in directed cases. Random accesses over a small address and value space then separate each condition code, width mode and mask against the bench model.

// File: rtl/watch_pkg.sv
package watch_pkg;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    localparam logic [1:0] WM_BYTE = 2'd0;
    localparam logic [1:0] WM_HALF = 2'd1;

    localparam logic [2:0] C_EQ = 3'd1;
    localparam logic [2:0] C_NE = 3'd2;
    localparam logic [2:0] C_GT = 3'd3;
    localparam logic [2:0] C_LT = 3'd4;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRE  = 2'd2
    } evt_state_e;

    // Condition outcome from the three relations; unknown codes mean "off".
    function automatic logic cond_eval(input logic [2:0] c, input logic eq,
                                       input logic gt, input logic lt);
        logic r;
        unique case (c)
            C_EQ:    r = eq;
            C_NE:    r = !eq;
            C_GT:    r = gt;
            C_LT:    r = lt;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/watch_regs.sv
module watch_regs #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int NA = 2,
    parameter int ND = 2,
    parameter int SW = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [SW-1:0]             cfg_sel,
    input  logic [31:0]               cfg_wdata,
    output logic                      glb_en,
    output logic [NA-1:0][AW-1:0]     a_ref,
    output logic [NA-1:0][2:0]        a_cond,
    output logic [ND-1:0][DW-1:0]     d_ref,
    output logic [ND-1:0][2:0]        d_cond,
    output logic [ND-1:0][1:0]        d_wid,
    output logic [ND-1:0][DW/8-1:0]   d_mask
);
    localparam int NB      = DW / 8;
    localparam int BASE_AR = 1;
    localparam int BASE_AC = BASE_AR + NA;
    localparam int BASE_DR = BASE_AC + NA;
    localparam int BASE_DC = BASE_DR + ND;

    always_ff @(posedge clk) begin
        if (rst) glb_en <= 1'b0;
        else if (cfg_we && cfg_sel == SW'(0)) glb_en <= cfg_wdata[0];
    end

    for (genvar i = 0; i < NA; i++) begin : g_areg
        always_ff @(posedge clk) begin
            if (rst) begin
                a_ref[i]  <= '0;
                a_cond[i] <= 3'd0;
            end else if (cfg_we) begin
                if (cfg_sel == SW'(BASE_AR + i)) a_ref[i]  <= cfg_wdata[AW-1:0];
                if (cfg_sel == SW'(BASE_AC + i)) a_cond[i] <= cfg_wdata[2:0];
            end
        end
    end

    for (genvar j = 0; j < ND; j++) begin : g_dreg
        always_ff @(posedge clk) begin
            if (rst) begin
                d_ref[j]  <= '0;
                d_cond[j] <= 3'd0;
                d_wid[j]  <= 2'd2;
                d_mask[j] <= '0;
            end else if (cfg_we) begin
                if (cfg_sel == SW'(BASE_DR + j)) d_ref[j] <= cfg_wdata[DW-1:0];
                if (cfg_sel == SW'(BASE_DC + j)) begin
                    d_cond[j] <= cfg_wdata[2:0];
                    d_wid[j]  <= cfg_wdata[5:4];
                    d_mask[j] <= cfg_wdata[8 +: NB];
                end
            end
        end
    end

endmodule

// File: rtl/watch_addr_cmp.sv
module watch_addr_cmp
    import watch_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic [AW-1:0] ref_val,
    input  logic [2:0]    cond,
    output logic          hit
);
    logic [AW-1:0] keep;
    logic [AW-1:0] a_m;
    logic [AW-1:0] r_m;

    always_comb begin
        unique case (size)
            SZ_BYTE: keep = '1;
            SZ_HALF: keep = {{(AW-1){1'b1}}, 1'b0};
            default: keep = {{(AW-2){1'b1}}, 2'b00};
        endcase
        a_m = addr & keep;
        r_m = ref_val & keep;
        hit = cond_eval(cond, a_m == r_m, a_m > r_m, a_m < r_m);
    end

    // R1: a word access matches an equal reference whatever its two low bits
    a_r1_word_low_bits: assert property (@(posedge clk) disable iff (rst)
        (size[1] && cond == C_EQ && addr[AW-1:2] == ref_val[AW-1:2]) |-> hit);

endmodule

// File: rtl/watch_data_cmp.sv
module watch_data_cmp
    import watch_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   data,
    input  logic [DW-1:0]   ref_val,
    input  logic [2:0]      cond,
    input  logic [1:0]      wid,
    input  logic [DW/8-1:0] mask,
    output logic            hit
);
    localparam int NB = DW / 8;
    localparam int NH = NB / 2;

    logic [NB-1:0] byte_ok;
    logic [NH-1:0] half_ok;
    logic          word_ok;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [7:0] dv, rv;
        assign dv = data[8*i +: 8];
        assign rv = ref_val[8*i +: 8];
        assign byte_ok[i] = mask[i] | cond_eval(cond, dv == rv, dv > rv, dv < rv);
    end

    for (genvar k = 0; k < NH; k++) begin : g_half
        logic [15:0] dv, rv;
        assign dv = data[16*k +: 16];
        assign rv = ref_val[16*k +: 16];
        assign half_ok[k] = (mask[2*k] & mask[2*k+1])
                          | cond_eval(cond, dv == rv, dv > rv, dv < rv);
    end

    assign word_ok = cond_eval(cond, data == ref_val, data > ref_val, data < ref_val);

    always_comb begin
        unique case (wid)
            WM_BYTE: hit = &byte_ok;
            WM_HALF: hit = &half_ok;
            default: hit = word_ok;
        endcase
    end

    // R5: a lane mode with every lane excluded never blocks the event
    a_r5_all_masked_pass: assert property (@(posedge clk) disable iff (rst)
        (!wid[1] && &mask) |-> hit);

endmodule

// File: rtl/watch_evt_fsm.sv
module watch_evt_fsm
    import watch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic glb_en,
    input  logic acc_valid,
    input  logic match,
    output logic evt
);
    evt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        if (!glb_en)                 state_d = ST_OFF;
        else if (acc_valid && match) state_d = ST_FIRE;
        else                         state_d = ST_ARMED;
    end

    always_comb begin
        unique case (state_q)
            ST_FIRE: evt = 1'b1;
            default: evt = 1'b0;
        endcase
    end

    // R7: a qualifying access yields the event on the next cycle
    a_r7_fire_after_hit: assert property (@(posedge clk) disable iff (rst)
        (glb_en && acc_valid && match) |=> evt);
    // R7: no event without an access strobe
    a_r7_quiet_without_valid: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !evt);
    // R8: global enable clear keeps the event low
    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> !evt);

endmodule

// File: rtl/ldst_watch.sv
module ldst_watch
    import watch_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int NA = 2,
    parameter int ND = 2,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    input  logic [DW-1:0] acc_data,
    output logic          evt
);
    localparam int NB = DW / 8;
    localparam int NH = NB / 2;

    logic                    glb_en;
    logic [NA-1:0][AW-1:0]   a_ref;
    logic [NA-1:0][2:0]      a_cond;
    logic [ND-1:0][DW-1:0]   d_ref;
    logic [ND-1:0][2:0]      d_cond;
    logic [ND-1:0][1:0]      d_wid;
    logic [ND-1:0][NB-1:0]   d_mask;
    logic [DW-1:0]           lanes;
    logic [NA-1:0]           a_hit;
    logic [ND-1:0]           d_hit;
    logic                    match;

    watch_regs #(.AW(AW), .DW(DW), .NA(NA), .ND(ND), .SW(SW)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .glb_en(glb_en), .a_ref(a_ref), .a_cond(a_cond),
        .d_ref(d_ref), .d_cond(d_cond), .d_wid(d_wid), .d_mask(d_mask)
    );

    // Spread narrow data over every lane so lane positions match a word access.
    always_comb begin
        unique case (acc_size)
            SZ_BYTE: lanes = {NB{acc_data[7:0]}};
            SZ_HALF: lanes = {NH{acc_data[15:0]}};
            default: lanes = acc_data;
        endcase
    end

    for (genvar i = 0; i < NA; i++) begin : g_acmp
        watch_addr_cmp #(.AW(AW)) u_acmp (
            .clk(clk), .rst(rst), .addr(acc_addr), .size(acc_size),
            .ref_val(a_ref[i]), .cond(a_cond[i]), .hit(a_hit[i])
        );
    end

    for (genvar j = 0; j < ND; j++) begin : g_dcmp
        watch_data_cmp #(.DW(DW)) u_dcmp (
            .clk(clk), .rst(rst), .data(lanes), .ref_val(d_ref[j]),
            .cond(d_cond[j]), .wid(d_wid[j]), .mask(d_mask[j]), .hit(d_hit[j])
        );
    end

    assign match = (&a_hit) & (&d_hit);

    watch_evt_fsm u_fsm (
        .clk(clk), .rst(rst), .glb_en(glb_en), .acc_valid(acc_valid),
        .match(match), .evt(evt)
    );

    // R6: any comparator failing blocks the next-cycle event
    a_r6_and_combine: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !(&a_hit && &d_hit)) |=> !evt);

endmodule

// File: tb/test_ldst_watch.sv
module test_ldst_watch;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [1:0]  acc_size;
    logic [31:0] acc_data;
    logic        evt;

    int checks = 0;
    int errors = 0;

    // bench copy of programmed state (R10 map)
    bit          m_en;
    logic [31:0] m_aref  [2];
    logic [2:0]  m_acond [2];
    logic [31:0] m_dref  [2];
    logic [2:0]  m_dcond [2];
    logic [1:0]  m_dwid  [2];
    logic [3:0]  m_dmask [2];

    always #5 clk = ~clk;

    ldst_watch i_ldst_watch (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_data(acc_data), .evt(evt)
    );

    function automatic bit rel(logic [2:0] c, logic [31:0] x, logic [31:0] r);
        case (c)
            3'd1: return x == r;
            3'd2: return x != r;
            3'd3: return x > r;
            3'd4: return x < r;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit model(logic [31:0] a, logic [1:0] s, logic [31:0] d);
        logic [31:0] km, dd;
        bit ok;
        ok = m_en;
        km = (s == 2'd0) ? 32'hFFFF_FFFF : (s == 2'd1) ? 32'hFFFF_FFFE : 32'hFFFF_FFFC; // R1
        dd = (s == 2'd0) ? {4{d[7:0]}} : (s == 2'd1) ? {2{d[15:0]}} : d;               // R3
        for (int n = 0; n < 2; n++) begin
            ok &= rel(m_acond[n], a & km, m_aref[n] & km);
            if (m_dwid[n] == 2'd0) begin
                for (int i = 0; i < 4; i++)
                    if (!m_dmask[n][i])
                        ok &= rel(m_dcond[n], {24'd0, dd[8*i +: 8]}, {24'd0, m_dref[n][8*i +: 8]});
            end else if (m_dwid[n] == 2'd1) begin
                for (int k = 0; k < 2; k++)
                    if (!(m_dmask[n][2*k] && m_dmask[n][2*k+1]))
                        ok &= rel(m_dcond[n], {16'd0, dd[16*k +: 16]}, {16'd0, m_dref[n][16*k +: 16]});
            end else begin
                ok &= rel(m_dcond[n], dd, m_dref[n]);
            end
        end
        return ok;
    endfunction

    task automatic wr(input logic [3:0] sel, input logic [31:0] v);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            4'd0: m_en = v[0];
            4'd1: m_aref[0] = v;
            4'd2: m_aref[1] = v;
            4'd3: m_acond[0] = v[2:0];
            4'd4: m_acond[1] = v[2:0];
            4'd5: m_dref[0] = v;
            4'd6: m_dref[1] = v;
            4'd7: begin m_dcond[0] = v[2:0]; m_dwid[0] = v[5:4]; m_dmask[0] = v[11:8]; end
            4'd8: begin m_dcond[1] = v[2:0]; m_dwid[1] = v[5:4]; m_dmask[1] = v[11:8]; end
            default: ;
        endcase
    endtask

    task automatic chk(input bit exp, input string tag);
        checks++;
        if (evt !== exp) begin
            errors++;
            $display("FAIL %s evt=%b expected=%b", tag, evt, exp);
        end
    endtask

    task automatic acc(input logic [31:0] a, input logic [1:0] s,
                       input logic [31:0] d, input bit exp, input string tag);
        acc_valid = 1'b1; acc_addr = a; acc_size = s; acc_data = d;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(exp, tag);
    endtask

    function automatic logic [31:0] dcfg(logic [2:0] c, logic [1:0] w, logic [3:0] m);
        return {20'd0, m, 2'd0, w, 1'b0, c};
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        acc_valid = 1'b0; acc_addr = '0; acc_size = '0; acc_data = '0;
        m_en = 1'b0;
        for (int n = 0; n < 2; n++) begin
            m_aref[n] = '0; m_acond[n] = '0; m_dref[n] = '0;
            m_dcond[n] = '0; m_dwid[n] = 2'd2; m_dmask[n] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(1'b0, "R9 reset evt low");
        acc(32'h3, 2'd0, 32'h9, 1'b0, "R9 unprogrammed access");

        // R6: everything off, enable on -> every access fires
        wr(4'd0, 32'h1);
        acc(32'h40, 2'd2, 32'hDEAD_BEEF, 1'b1, "R6 all comparators off");
        @(negedge clk);
        chk(1'b0, "R7 single-cycle pulse");
        wr(4'd9, 32'h7);   // R10 unused select must not disturb anything
        acc(32'h44, 2'd2, 32'h0, 1'b1, "R10 unused select ignored");

        // byte target at address 3, 0x07 < v < 0x0C
        wr(4'd1, 32'h3);  wr(4'd3, 32'd1);
        wr(4'd5, 32'h7);  wr(4'd6, 32'hC);
        wr(4'd7, dcfg(3'd3, 2'd0, 4'hE));
        wr(4'd8, dcfg(3'd4, 2'd0, 4'hE));
        acc(32'h3, 2'd0, 32'h09, 1'b1, "R3 byte access in range");
        acc(32'h2, 2'd1, 32'h0009, 1'b1, "R1 half access covers byte");
        acc(32'h0, 2'd2, 32'hAABB_CC09, 1'b1, "R5 word access masked lanes");
        acc(32'h0, 2'd2, 32'h0000_000C, 1'b0, "R2 less-than upper bound");
        acc(32'h0, 2'd2, 32'h0000_0007, 1'b0, "R2 greater-than lower bound");
        acc(32'h4, 2'd2, 32'h0000_0009, 1'b0, "R1 other word");
        acc(32'h2, 2'd0, 32'h09, 1'b0, "R1 byte uses all bits");

        // half-word ranges
        wr(4'd1, 32'h0);  wr(4'd3, 32'd3);
        wr(4'd2, 32'hC);  wr(4'd4, 32'd4);
        wr(4'd5, 32'h4E20_4E20); wr(4'd6, 32'h9C40_9C40);
        wr(4'd7, dcfg(3'd3, 2'd1, 4'h0));
        wr(4'd8, dcfg(3'd4, 2'd1, 4'h0));
        acc(32'h2, 2'd1, 32'h7530, 1'b1, "R3 half access replicated");
        acc(32'h4, 2'd2, 32'h7530_7530, 1'b1, "R5 word access both halves");
        acc(32'h8, 2'd2, 32'h7530_4E20, 1'b0, "R5 one half on bound");
        acc(32'hC, 2'd1, 32'h7530, 1'b0, "R1 upper address bound");
        acc(32'h1, 2'd1, 32'h7530, 1'b0, "R1 half ignores bit0 at lower bound");
        wr(4'd7, dcfg(3'd3, 2'd1, 4'h3));
        acc(32'h8, 2'd2, 32'h7530_4E20, 1'b1, "R5 half excluded by two mask bits");

        // word mode equality, mask ignored
        wr(4'd3, 32'd0); wr(4'd4, 32'd0); wr(4'd8, dcfg(3'd0, 2'd2, 4'h0));
        wr(4'd5, 32'h1234_5678); wr(4'd7, dcfg(3'd1, 2'd2, 4'hF));
        acc(32'h10, 2'd2, 32'h1234_5678, 1'b1, "R4 word equal");
        acc(32'h10, 2'd2, 32'h1234_5679, 1'b0, "R4 word mask ignored");

        // lane-wise not equal
        wr(4'd5, 32'h0102_0304); wr(4'd7, dcfg(3'd2, 2'd0, 4'h0));
        acc(32'h10, 2'd2, 32'h0506_0708, 1'b1, "R2 not-equal all lanes");
        acc(32'h10, 2'd2, 32'h0502_0708, 1'b0, "R2 not-equal one lane same");
        wr(4'd7, dcfg(3'd6, 2'd0, 4'h0));
        acc(32'h10, 2'd2, 32'h0102_0304, 1'b1, "R2 code 6 off");

        // global enable
        wr(4'd0, 32'h0);
        acc(32'h10, 2'd2, 32'h0, 1'b0, "R8 disabled");
        wr(4'd0, 32'h1);

        // constrained random
        for (int it = 0; it < 600; it++) begin
            logic [31:0] a, d;
            logic [1:0]  s;
            bit e;
            if (it % 25 == 0) begin
                for (int n = 0; n < 2; n++) begin
                    wr(4'(1 + n), $urandom % 16);
                    wr(4'(3 + n), $urandom % 8);
                    wr(4'(5 + n), {4'd0, 4'($urandom), 4'd0, 4'($urandom),
                                   4'd0, 4'($urandom), 4'd0, 4'($urandom)});
                    wr(4'(7 + n), dcfg(3'($urandom % 8), 2'($urandom), 4'($urandom)));
                end
                wr(4'd0, {31'd0, ($urandom % 8) != 0});
            end
            a = $urandom % 16;
            s = 2'($urandom % 4);
            d = {4'd0, 4'($urandom), 4'd0, 4'($urandom),
                 4'd0, 4'($urandom), 4'd0, 4'($urandom)};
            e = model(a, s, d);
            acc(a, s, d, e, "R6 random vs model");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule